// File: doc/BRIEF.md
# Pending Miss Occupancy Event Counter

This block watches a small pool of miss fill-buffer entries and feeds four programmable event counters from their state. Every cycle it receives per-entry allocate, release and demand-hit strobes, a request-type flag on each allocation, and two plain stall indications. The first stall indication says a demand access is waiting because no fill-buffer entry is free. The second says the access is waiting on lower-level resources.

From these inputs it forms a raw per-cycle event value. Each counter has its own configuration word that selects the event, applies an optional threshold and rising-edge qualifier, and gates counting with an enable bit. The qualified increment is added to a 48-bit counter that wraps around and raises a sticky overflow flag.

Software programs and reads the counters through a plain register port. Writes take effect at the next clock edge. Reads are combinational. The port has no handshake because every register write and read completes in a single cycle, so no back-pressure can arise.

Top module: `miss_occ_pmu`

## Requirements
- R1: With event code 0x48 and unit-mask bit 0 selected and a zero threshold, a counter adds, on each clock, the number of pool entries that are demand-owned during that cycle. This number never exceeds the pool size.
- R2: An entry allocated with `alloc_demand`=1 is demand-owned from the cycle after its allocation edge up to and including the cycle in which `dealloc_valid` is asserted for it.
- R3: An entry allocated with `alloc_demand`=0 (a prefetch) becomes demand-owned only in the cycle after its first `demand_hit`, and it stays owned through its release cycle. A hit on an empty entry, or a hit in the same cycle as that entry's allocation or release, has no effect.
- R4: Under code 0x48, unit-mask bit 1 adds `fb_full_wait` and bit 2 adds `lower_stall`, and the selected terms are summed. Any other code gives a raw value of 0.
- R5: When the threshold field (config bits 25:18) is non-zero, the increment is 1 when the raw value is at least the threshold and 0 otherwise.
- R6: When the edge bit (config bit 16) is set together with a non-zero threshold, the increment is 1 only in a cycle whose thresholded condition is true after a false cycle.
- R7: Writing a counter's configuration clears its edge history, so a condition that is still true two cycles after the write counts once more.
- R8: The four counters are independent. Programming or counting on one counter leaves the others unchanged.
- R9: A counter whose enable bit (config bit 17) is clear holds its value.
- R10: A write to the count register loads the written value at the next edge, and this load overrides that cycle's increment.
- R11: A count that passes 2^48-1 wraps modulo 2^48 and sets a sticky overflow flag. Writing 1 to bit 0 of the overflow register clears the flag, but a new overflow in the same cycle wins over the clear.
- R12: The register address is {counter index, selector}. Selector 0 is the configuration word (code in bits 7:0, unit mask in 15:8, edge in 16, enable in 17, threshold in 25:18). Selector 1 is the count. Selector 2 is the overflow flag in bit 0. Selector 3 reads as 0.
- R13: After reset every entry is empty, and all configurations, counts, flags and edge histories are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 12 | Per-entry allocate strobe |
| alloc_demand | input | 12 | Allocation type: 1 for a demand read, 0 for a prefetch |
| dealloc_valid | input | 12 | Per-entry release strobe |
| demand_hit | input | 12 | Demand access hits the entry |
| fb_full_wait | input | 1 | A demand access waits because no entry is free |
| lower_stall | input | 1 | A demand access waits on lower-level resources |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Write address {index, selector} |
| reg_wdata | input | 48 | Write data |
| reg_rd_addr | input | 4 | Read address {index, selector} |
| reg_rdata | output | 48 | Combinational read data |

## Verification
The occupancy path is driven in three ways: a single demand entry, a prefetch entry that is hit late, and two demand entries that overlap. Together these show the difference between counting from allocation, counting from the first hit, and summing several entries. The threshold counter follows the same traffic, so the gap between its total and the raw total exposes the any-pending reduction.

The buffer-full indication is held over separate runs, and the configuration is rewritten while the condition is still true. This shows episode counting apart from cycle counting and proves that a rewrite clears the edge history.

A stall run across the 48-bit boundary, a count write that lands on a busy cycle, a disabled counter and a foreign event code each isolate one of the wrap, priority, enable and selection rules.

// File: rtl/miss_occ_pkg.sv
package miss_occ_pkg;
  localparam int CFG_W = 26;
  localparam logic [7:0] EVT_MISS_CODE = 8'h48;
  localparam logic [1:0] SEL_CFG = 2'd0;
  localparam logic [1:0] SEL_CNT = 2'd1;
  localparam logic [1:0] SEL_OVF = 2'd2;

  typedef struct packed {
    logic [7:0] cmask;
    logic       en;
    logic       edge_det;
    logic [7:0] umask;
    logic [7:0] code;
  } ctr_cfg_t;
endpackage

// File: rtl/fb_tracker.sv
module fb_tracker #(
  parameter int N_ENTRIES = 12,
  localparam int OCC_W = $clog2(N_ENTRIES + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_ENTRIES-1:0] alloc_valid,
  input  logic [N_ENTRIES-1:0] alloc_demand,
  input  logic [N_ENTRIES-1:0] dealloc_valid,
  input  logic [N_ENTRIES-1:0] demand_hit,
  output logic [N_ENTRIES-1:0] owned,
  output logic [OCC_W-1:0]     occ
);
  logic [N_ENTRIES-1:0] busy_q;

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[e] <= 1'b0;
        owned[e]  <= 1'b0;
      end else if (dealloc_valid[e]) begin
        busy_q[e] <= 1'b0;
        owned[e]  <= 1'b0;
      end else if (alloc_valid[e]) begin
        busy_q[e] <= 1'b1;
        owned[e]  <= alloc_demand[e];
      end else if (demand_hit[e] && busy_q[e]) begin
        owned[e]  <= 1'b1;
      end
    end
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < N_ENTRIES; i++) occ = occ + OCC_W'(owned[i]);
  end
endmodule

// File: rtl/event_select.sv
module event_select #(
  parameter int OCC_W = 4,
  parameter int RAW_W = 4
) (
  input  logic [7:0]       code,
  input  logic [7:0]       umask,
  input  logic [OCC_W-1:0] occ,
  input  logic             fb_full_wait,
  input  logic             lower_stall,
  output logic [RAW_W-1:0] raw
);
  import miss_occ_pkg::*;
  always_comb begin
    raw = '0;
    if (code == EVT_MISS_CODE) begin
      if (umask[0]) raw = raw + RAW_W'(occ);
      if (umask[1]) raw = raw + RAW_W'(fb_full_wait);
      if (umask[2]) raw = raw + RAW_W'(lower_stall);
    end
  end
endmodule

// File: rtl/ctr_slice.sv
module ctr_slice #(
  parameter int CTR_W = 48,
  parameter int RAW_W = 4,
  localparam int CMP_W = (RAW_W > 8) ? RAW_W : 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wr,
  input  logic                    cnt_wr,
  input  logic                    ovf_clr,
  input  logic [CTR_W-1:0]        wdata,
  input  logic [RAW_W-1:0]        raw,
  output miss_occ_pkg::ctr_cfg_t  cfg_q,
  output logic [RAW_W-1:0]        inc,
  output logic [CTR_W-1:0]        cnt_q,
  output logic                    ovf_q
);
  import miss_occ_pkg::*;
  logic             cond, prev_q;
  logic [CTR_W:0]   sum;

  always_comb begin
    cond = CMP_W'(raw) >= CMP_W'(cfg_q.cmask);
    if (cfg_q.cmask == '0)  inc = raw;
    else if (cfg_q.edge_det) inc = RAW_W'(cond && !prev_q);
    else                     inc = RAW_W'(cond);
    sum = {1'b0, cnt_q} + (CTR_W + 1)'(inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (cfg_wr) cfg_q <= ctr_cfg_t'(wdata[CFG_W-1:0]);
      prev_q <= cfg_wr ? 1'b0 : cond;
      if (cnt_wr)          cnt_q <= wdata;
      else if (cfg_q.en)   cnt_q <= sum[CTR_W-1:0];
      if (cfg_q.en && !cnt_wr && sum[CTR_W]) ovf_q <= 1'b1;
      else if (ovf_clr)                      ovf_q <= 1'b0;
    end
  end
endmodule

// File: rtl/miss_occ_pmu.sv
module miss_occ_pmu #(
  parameter int N_ENTRIES = 12,
  parameter int NUM_CTRS  = 4,
  parameter int CTR_W     = 48,
  localparam int OCC_W  = $clog2(N_ENTRIES + 1),
  localparam int RAW_W  = $clog2(N_ENTRIES + 3),
  localparam int IDX_W  = $clog2(NUM_CTRS),
  localparam int ADDR_W = IDX_W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [N_ENTRIES-1:0] alloc_valid,
  input  logic [N_ENTRIES-1:0] alloc_demand,
  input  logic [N_ENTRIES-1:0] dealloc_valid,
  input  logic [N_ENTRIES-1:0] demand_hit,
  input  logic                 fb_full_wait,
  input  logic                 lower_stall,
  input  logic                 reg_wr_en,
  input  logic [ADDR_W-1:0]    reg_wr_addr,
  input  logic [CTR_W-1:0]     reg_wdata,
  input  logic [ADDR_W-1:0]    reg_rd_addr,
  output logic [CTR_W-1:0]     reg_rdata
);
  import miss_occ_pkg::*;

  logic [N_ENTRIES-1:0]             owned;
  logic [OCC_W-1:0]                 occ;
  ctr_cfg_t [NUM_CTRS-1:0]          cfg_all;
  logic [NUM_CTRS-1:0][RAW_W-1:0]   inc_all;
  logic [NUM_CTRS-1:0][CTR_W-1:0]   cnt_all;
  logic [NUM_CTRS-1:0]              ovf_all;

  fb_tracker #(.N_ENTRIES(N_ENTRIES)) u_trk (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_demand(alloc_demand),
    .dealloc_valid(dealloc_valid), .demand_hit(demand_hit), .owned(owned), .occ(occ));

  for (genvar g = 0; g < NUM_CTRS; g++) begin : g_ctr
    logic             hit_idx;
    logic [RAW_W-1:0] raw;
    assign hit_idx = reg_wr_en && (reg_wr_addr[ADDR_W-1:2] == IDX_W'(g));

    event_select #(.OCC_W(OCC_W), .RAW_W(RAW_W)) u_sel (
      .code(cfg_all[g].code), .umask(cfg_all[g].umask), .occ(occ),
      .fb_full_wait(fb_full_wait), .lower_stall(lower_stall), .raw(raw));

    ctr_slice #(.CTR_W(CTR_W), .RAW_W(RAW_W)) u_ctr (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr(hit_idx && reg_wr_addr[1:0] == SEL_CFG),
      .cnt_wr(hit_idx && reg_wr_addr[1:0] == SEL_CNT),
      .ovf_clr(hit_idx && reg_wr_addr[1:0] == SEL_OVF && reg_wdata[0]),
      .wdata(reg_wdata), .raw(raw), .cfg_q(cfg_all[g]), .inc(inc_all[g]),
      .cnt_q(cnt_all[g]), .ovf_q(ovf_all[g]));
  end

  always_comb begin
    case (reg_rd_addr[1:0])
      SEL_CFG: reg_rdata = CTR_W'(cfg_all[reg_rd_addr[ADDR_W-1:2]]);
      SEL_CNT: reg_rdata = cnt_all[reg_rd_addr[ADDR_W-1:2]];
      SEL_OVF: reg_rdata = CTR_W'(ovf_all[reg_rd_addr[ADDR_W-1:2]]);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/miss_occ_pmu_chk.sv
module miss_occ_pmu_chk #(
  parameter int N_ENTRIES = 12,
  parameter int NUM_CTRS  = 4,
  parameter int CTR_W     = 48,
  parameter int OCC_W     = 4,
  parameter int RAW_W     = 4,
  parameter int IDX_W     = 2,
  parameter int ADDR_W    = 4
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [N_ENTRIES-1:0]               alloc_valid,
  input logic [N_ENTRIES-1:0]               alloc_demand,
  input logic [N_ENTRIES-1:0]               dealloc_valid,
  input logic [N_ENTRIES-1:0]               owned,
  input logic [OCC_W-1:0]                   occ,
  input logic                               reg_wr_en,
  input logic [ADDR_W-1:0]                  reg_wr_addr,
  input logic [CTR_W-1:0]                   reg_wdata,
  input miss_occ_pkg::ctr_cfg_t [NUM_CTRS-1:0] cfg_all,
  input logic [NUM_CTRS-1:0][RAW_W-1:0]     inc_all,
  input logic [NUM_CTRS-1:0][CTR_W-1:0]     cnt_all,
  input logic [NUM_CTRS-1:0]                ovf_all
);
  import miss_occ_pkg::*;

  assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= OCC_W'(N_ENTRIES));

  for (genvar e = 0; e < N_ENTRIES; e++) begin : g_e
    assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      dealloc_valid[e] |=> !owned[e]);
    assert_pf_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (alloc_valid[e] && !alloc_demand[e] && !dealloc_valid[e]) |=> !owned[e]);
  end

  for (genvar c = 0; c < NUM_CTRS; c++) begin : g_c
    logic cnt_wr, clr_wr;
    assign cnt_wr = reg_wr_en && reg_wr_addr == {IDX_W'(c), SEL_CNT};
    assign clr_wr = reg_wr_en && reg_wr_addr == {IDX_W'(c), SEL_OVF} && reg_wdata[0];

    assert_edge_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_all[c].cmask != 8'd0) |-> inc_all[c] <= RAW_W'(1));
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_all[c].en && !cnt_wr) |=> $stable(cnt_all[c]));
    assert_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> cnt_all[c] == $past(reg_wdata));
    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_all[c] && !clr_wr) |=> ovf_all[c]);
  end
endmodule

bind miss_occ_pmu miss_occ_pmu_chk #(
  .N_ENTRIES(N_ENTRIES), .NUM_CTRS(NUM_CTRS), .CTR_W(CTR_W), .OCC_W(OCC_W),
  .RAW_W(RAW_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_demand(alloc_demand),
  .dealloc_valid(dealloc_valid), .owned(owned), .occ(occ), .reg_wr_en(reg_wr_en),
  .reg_wr_addr(reg_wr_addr), .reg_wdata(reg_wdata), .cfg_all(cfg_all),
  .inc_all(inc_all), .cnt_all(cnt_all), .ovf_all(ovf_all));

// File: tb/miss_occ_pmu_tb.sv
`timescale 1ns/1ps
module miss_occ_pmu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] alloc_valid = '0, alloc_demand = '0, dealloc_valid = '0, demand_hit = '0;
  logic        fb_full_wait = 1'b0, lower_stall = 1'b0, reg_wr_en = 1'b0;
  logic [3:0]  reg_wr_addr = '0, reg_rd_addr = '0;
  logic [47:0] reg_wdata = '0;
  logic [47:0] reg_rdata;

  int checks = 0, errors = 0;
  string phase = "R13";
  logic [3:0] rot = '0;

  always #2.5 clk = ~clk;

  miss_occ_pmu dut_i (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_demand(alloc_demand),
    .dealloc_valid(dealloc_valid), .demand_hit(demand_hit), .fb_full_wait(fb_full_wait),
    .lower_stall(lower_stall), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
    .reg_wdata(reg_wdata), .reg_rd_addr(reg_rd_addr), .reg_rdata(reg_rdata));

  // behavioural reference model
  bit        m_v[12], m_dc[12];
  bit [25:0] m_cfg[4];
  bit [47:0] m_cnt[4];
  bit        m_ovf[4], m_prev[4];

  always @(posedge clk or negedge rst_n) begin
    int occ, raw;
    bit cond, hit;
    bit [7:0] code, um, cm;
    bit [48:0] s;
    int inc;
    if (!rst_n) begin
      for (int i = 0; i < 12; i++) begin m_v[i] = 0; m_dc[i] = 0; end
      for (int c = 0; c < 4; c++) begin
        m_cfg[c] = 0; m_cnt[c] = 0; m_ovf[c] = 0; m_prev[c] = 0;
      end
    end else begin
      occ = 0;
      for (int i = 0; i < 12; i++) occ += m_dc[i];
      for (int c = 0; c < 4; c++) begin
        code = m_cfg[c][7:0]; um = m_cfg[c][15:8]; cm = m_cfg[c][25:18];
        raw = 0;
        if (code == 8'h48) raw = (um[0] ? occ : 0) + (um[1] ? int'(fb_full_wait) : 0)
                               + (um[2] ? int'(lower_stall) : 0);
        cond = raw >= int'(cm);
        inc = (cm == 0) ? raw : (m_cfg[c][16] ? int'(cond && !m_prev[c]) : int'(cond));
        hit = reg_wr_en && reg_wr_addr[3:2] == c[1:0];
        m_prev[c] = (hit && reg_wr_addr[1:0] == 0) ? 1'b0 : cond;
        s = {1'b0, m_cnt[c]} + 49'(inc);
        if (hit && reg_wr_addr[1:0] == 1) m_cnt[c] = reg_wdata;
        else if (m_cfg[c][17]) begin
          m_cnt[c] = s[47:0];
          if (s[48]) m_ovf[c] = 1;
          else if (hit && reg_wr_addr[1:0] == 2 && reg_wdata[0]) m_ovf[c] = 0;
        end else if (hit && reg_wr_addr[1:0] == 2 && reg_wdata[0]) m_ovf[c] = 0;
        if (hit && reg_wr_addr[1:0] == 0) m_cfg[c] = reg_wdata[25:0];
      end
      for (int i = 0; i < 12; i++) begin
        if (dealloc_valid[i]) begin m_v[i] = 0; m_dc[i] = 0; end
        else if (alloc_valid[i]) begin m_v[i] = 1; m_dc[i] = alloc_demand[i]; end
        else if (demand_hit[i] && m_v[i]) m_dc[i] = 1;
      end
    end
  end

  function automatic logic [47:0] mread(logic [3:0] a);
    case (a[1:0])
      2'd0: return 48'(m_cfg[a[3:2]]);
      2'd1: return m_cnt[a[3:2]];
      2'd2: return 48'(m_ovf[a[3:2]]);
      default: return 48'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [47:0] act, logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    check({phase, " model"}, reg_rdata, mread(reg_rd_addr));
    alloc_valid = '0; alloc_demand = '0; dealloc_valid = '0; demand_hit = '0;
    reg_wr_en = 1'b0;
    rot = rot + 4'd1;
    reg_rd_addr = rot;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(logic [3:0] a, logic [47:0] d);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wdata = d;
    tick();
  endtask

  task automatic rd(string tag, logic [3:0] a, logic [47:0] exp);
    reg_rd_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  function automatic logic [47:0] cfgw(int code, int um, int edg, int en, int cm);
    return 48'(code) | (48'(um) << 8) | (48'(edg) << 16) | (48'(en) << 17) | (48'(cm) << 18);
  endfunction

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < 16; a++) rd("R13 reset", 4'(a), 48'd0);

    phase = "R12";
    wr(4'h0, cfgw('h48, 1, 0, 1, 0));
    wr(4'h4, cfgw('h48, 1, 0, 1, 1));
    wr(4'h8, cfgw('h48, 2, 1, 1, 1));
    wr(4'hC, cfgw('h48, 4, 0, 1, 0));
    rd("R12 cfg readback", 4'h8, cfgw('h48, 2, 1, 1, 1));
    rd("R12 spare selector", 4'h3, 48'd0);

    phase = "R2";
    alloc_valid[0] = 1; alloc_demand[0] = 1; tick();
    demand_hit[5] = 1; idle(3);
    dealloc_valid[0] = 1; tick();
    rd("R2 demand span", 4'h1, 48'd4);
    phase = "R3";
    alloc_valid[1] = 1; tick();
    idle(2);
    demand_hit[1] = 1; tick();
    idle(2);
    dealloc_valid[1] = 1; tick();
    rd("R3 prefetch from hit", 4'h1, 48'd7);
    rd("R5 any pending", 4'h5, 48'd7);

    phase = "R1";
    alloc_valid[3:2] = 2'b11; alloc_demand[3:2] = 2'b11; tick();
    idle(2);
    dealloc_valid[3:2] = 2'b11; tick();
    rd("R1 summed occupancy", 4'h1, 48'd13);
    rd("R5 threshold cycles", 4'h5, 48'd10);

    phase = "R6";
    fb_full_wait = 1; idle(3);
    fb_full_wait = 0; tick();
    fb_full_wait = 1; idle(2);
    fb_full_wait = 0; tick();
    rd("R6 episodes", 4'h9, 48'd2);
    phase = "R7";
    fb_full_wait = 1; tick();
    wr(4'h8, cfgw('h48, 2, 1, 1, 1));
    idle(2);
    fb_full_wait = 0; tick();
    rd("R7 history cleared", 4'h9, 48'd4);

    phase = "R4";
    lower_stall = 1; idle(5);
    lower_stall = 0; tick();
    rd("R4 stall cycles", 4'hD, 48'd5);
    rd("R8 other counter untouched", 4'h9, 48'd4);

    phase = "R9";
    wr(4'h0, cfgw('h48, 1, 0, 0, 0));
    alloc_valid[4] = 1; alloc_demand[4] = 1; tick();
    idle(2);
    dealloc_valid[4] = 1; tick();
    rd("R9 disabled holds", 4'h1, 48'd13);
    rd("R8 enabled neighbour counts", 4'h5, 48'd13);

    phase = "R11";
    wr(4'hD, 48'hFFFF_FFFF_FFFE);
    lower_stall = 1; idle(3);
    lower_stall = 0; tick();
    rd("R11 wrap", 4'hD, 48'd1);
    rd("R11 overflow set", 4'hE, 48'd1);
    wr(4'hE, 48'd1);
    rd("R11 overflow cleared", 4'hE, 48'd0);

    phase = "R10";
    alloc_valid[6] = 1; alloc_demand[6] = 1; tick();
    wr(4'h5, 48'd100);
    rd("R10 load beats increment", 4'h5, 48'd100);
    dealloc_valid[6] = 1; tick();
    rd("R10 counts after load", 4'h5, 48'd101);

    phase = "R4";
    wr(4'hC, cfgw('h11, 7, 0, 1, 0));
    lower_stall = 1; fb_full_wait = 1; idle(3);
    lower_stall = 0; fb_full_wait = 0; tick();
    rd("R4 foreign code", 4'hD, 48'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule